// File: doc/BRIEF.md
# GPIO Pin Mux and Output Controller

This block manages one bank of parallel I/O pins, 32 by default. For each pin it decides whether the pad is driven by the general-purpose logic or by one of four peripheral functions. When the general-purpose logic owns a pin, the block supplies the pad's output data and output enable. It also keeps per-pin pull-up, pull-down and open-drain settings, and it reports both the synchronized pad level and which pins it owns.

Software reaches the block through a simple word-addressed register bus. Most controls are grouped in set/clear pairs. A write to a set address turns on exactly the pins whose mask bits are 1. A write to the matching clear address turns them off. No other pin changes. The peripheral function of a pin is a 2-bit code made of one bit from each of two plain read/write select words.

Top module: `gpio_mux_bank`

## Requirements
- R1: Each set/clear pair changes only the masked pins, one clock edge after the write. The pairs sit at these word offsets (set/clear/status): ownership 0/1/2, output enable 3/4/5, output data 6/7/8, pull-up 9/10/11, pull-down 12/13/14, open-drain 15/16/17.
- R2: The ownership status word (offset 2) reads 1 for every pin that the general-purpose logic owns.
- R3: A pin not owned by the general-purpose logic takes its pad data and enable from the peripheral selected by {high-select bit, low-select bit}. Code 00 selects function 0, 01 function 1, 10 function 2 and 11 function 3. Peripheral bus bit f*32+pin belongs to function f.
- R4: A pin owned by the general-purpose logic, with open-drain off, drives pad_out from the output data register and pad_oe from the output enable register.
- R5: The level word (offset 20) returns pad_in delayed by two clock edges, whatever the pin's owner.
- R6: Setting pull-down on a pin also clears pull-up on that pin in the same edge. Pull-up changes only through its own pair otherwise. pad_pullup and pad_pulldown follow the registers.
- R7: With open-drain on, a pin never drives high. It enables the pad only when its data is 0, and it releases the pad when its data is 1.
- R8: The low-select word (offset 18) and the high-select word (offset 19) are read/write, and each returns the last value written to it.
- R9: After reset, every pin is owned by the general-purpose logic and pulled up. Output enable, output data, pull-down, open-drain and both select words are 0.
- R10: Set and clear addresses read as 0. Writes to status, level or unused addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data or pin mask |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Raw pad levels |
| periph_dout | input | 128 | Peripheral data, function-major |
| periph_oe | input | 128 | Peripheral enables, function-major |
| pad_out | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad output enable |
| pad_pullup | output | 32 | Pull-up enables |
| pad_pulldown | output | 32 | Pull-down enables |

## Verification
A register write takes effect at the clock edge where the strobe is sampled. After that edge, both the read data and the pad outputs show the new state, because readback and pad routing are combinational from the registers. The level readback lags pad_in by two edges. The bench therefore drives inputs and samples outputs at falling edges. It reads a register result one falling edge after the write. It checks the level word after exactly one edge, when the old value must still show, and again after two edges, when the new value must appear.

// File: rtl/gpio_mux_pkg.sv
// Shared constants for the GPIO pin mux bank: bus width, address map
// and the set/clear control group numbering.
package gpio_mux_pkg;
    localparam int ADDR_W  = 5;
    localparam int FUNC_W  = 2;
    localparam int NFUNC   = 1 << FUNC_W;
    // set/clear control groups; group g uses offsets 3g, 3g+1, 3g+2
    localparam int G_OWN   = 0;
    localparam int G_OE    = 1;
    localparam int G_OUT   = 2;
    localparam int G_PU    = 3;
    localparam int G_PD    = 4;
    localparam int G_OD    = 5;
    localparam int NGROUP  = 6;
    localparam logic [ADDR_W-1:0] A_SEL_LO = 5'd18;
    localparam logic [ADDR_W-1:0] A_SEL_HI = 5'd19;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 5'd20;
endpackage

// File: rtl/gpio_setclr_reg.sv
// Per-bit control register updated by write-one-to-set and
// write-one-to-clear masks. Assumes the masks are zero when no write
// targets this register; clear wins if both masks hit one bit.
module gpio_setclr_reg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    // update only the masked bits, keep the rest
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= (q | set_mask) & ~clr_mask;
    end

    assert_set_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0 && clr_mask == '0) |=> ((q & $past(set_mask)) == $past(set_mask)));
    assert_unmasked_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((q ^ $past(q)) & ~($past(set_mask) | $past(clr_mask))) == '0));
endmodule

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer for the pad levels. The flops have no reset:
// they keep shifting during reset, so the delay holds from the first
// cycle after reset. rst_n is used only to qualify the check.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // two-stage capture of the asynchronous pad levels
    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end

    assert_two_cycle_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(d, 2));
endmodule

// File: rtl/gpio_pin_route.sv
// Per-pin pad routing. It selects the GPIO registers or one of NFUNC
// peripheral functions by a 2-bit code, then applies open-drain shaping.
// Purely combinational; assumes the peripheral buses are function-major.
module gpio_pin_route
    import gpio_mux_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]       own_gpio,
    input  logic [NPINS-1:0]       gpio_oe,
    input  logic [NPINS-1:0]       gpio_out,
    input  logic [NPINS-1:0]       open_drain,
    input  logic [NPINS-1:0]       sel_lo,
    input  logic [NPINS-1:0]       sel_hi,
    input  logic [NFUNC*NPINS-1:0] periph_dout,
    input  logic [NFUNC*NPINS-1:0] periph_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [FUNC_W-1:0] code;
        logic              src_d, src_e;

        // choose the source of data and enable for this pin
        always_comb begin
            code = {sel_hi[p], sel_lo[p]};
            if (own_gpio[p]) begin
                src_d = gpio_out[p];
                src_e = gpio_oe[p];
            end else begin
                src_d = periph_dout[int'(code)*NPINS + p];
                src_e = periph_oe[int'(code)*NPINS + p];
            end
        end

        // open-drain: drive only low, release for high
        always_comb begin
            pad_out[p] = open_drain[p] ? 1'b0 : src_d;
            pad_oe[p]  = open_drain[p] ? (src_e & ~src_d) : src_e;
        end
    end
endmodule

// File: rtl/gpio_mux_bank.sv
// GPIO pin mux bank top. It holds the set/clear control groups and the
// two select words, decodes the register bus, synchronizes pad levels
// and routes every pin. Read data is combinational from the address.
module gpio_mux_bank
    import gpio_mux_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [NPINS-1:0]       bus_wdata,
    input  logic                   bus_we,
    output logic [NPINS-1:0]       bus_rdata,
    input  logic [NPINS-1:0]       pad_in,
    input  logic [NFUNC*NPINS-1:0] periph_dout,
    input  logic [NFUNC*NPINS-1:0] periph_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pad_pullup,
    output logic [NPINS-1:0]       pad_pulldown
);
    localparam int CTL_TOP = 3 * NGROUP;

    logic [NPINS-1:0] ctl_q   [NGROUP];
    logic [NPINS-1:0] set_m   [NGROUP];
    logic [NPINS-1:0] clr_m   [NGROUP];
    logic [NPINS-1:0] sel_lo_q, sel_hi_q, level_q;

    for (genvar g = 0; g < NGROUP; g++) begin : g_ctl
        localparam logic [NPINS-1:0] RV =
            (g == G_OWN || g == G_PU) ? '1 : '0;
        localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(3 * g);
        localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(3 * g + 1);
        logic [NPINS-1:0] extra_clr;

        // decode set/clear masks; a pull-down set also clears pull-up
        always_comb begin
            set_m[g]  = (bus_we && bus_addr == A_SET) ? bus_wdata : '0;
            extra_clr = '0;
            if (g == G_PU && bus_we && bus_addr == ADDR_W'(3 * G_PD))
                extra_clr = bus_wdata;
            clr_m[g]  = ((bus_we && bus_addr == A_CLR) ? bus_wdata : '0) | extra_clr;
        end

        gpio_setclr_reg #(.W(NPINS), .RST_VAL(RV)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_m[g]),
            .clr_mask (clr_m[g]),
            .q        (ctl_q[g])
        );
    end

    // plain read/write function-select words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lo_q <= '0;
            sel_hi_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_SEL_LO) sel_lo_q <= bus_wdata;
            if (bus_addr == A_SEL_HI) sel_hi_q <= bus_wdata;
        end
    end

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (level_q)
    );

    gpio_pin_route #(.NPINS(NPINS)) u_route (
        .own_gpio    (ctl_q[G_OWN]),
        .gpio_oe     (ctl_q[G_OE]),
        .gpio_out    (ctl_q[G_OUT]),
        .open_drain  (ctl_q[G_OD]),
        .sel_lo      (sel_lo_q),
        .sel_hi      (sel_hi_q),
        .periph_dout (periph_dout),
        .periph_oe   (periph_oe),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe)
    );

    // read mux: status words, select words and synchronized level
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) < CTL_TOP) begin
            if (int'(bus_addr) % 3 == 2) bus_rdata = ctl_q[int'(bus_addr) / 3];
        end else if (bus_addr == A_SEL_LO) begin
            bus_rdata = sel_lo_q;
        end else if (bus_addr == A_SEL_HI) begin
            bus_rdata = sel_hi_q;
        end else if (bus_addr == A_LEVEL) begin
            bus_rdata = level_q;
        end
    end

    // drive the pad bias outputs from the registers
    always_comb begin
        pad_pullup   = ctl_q[G_PU];
        pad_pulldown = ctl_q[G_PD];
    end

    assert_pulldown_drops_pullup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(3 * G_PD)) |=> ((pad_pullup & $past(bus_wdata)) == '0));
    assert_open_drain_no_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & ctl_q[G_OD]) == '0);
    assert_sel_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SEL_LO) |=> (sel_lo_q == $past(bus_wdata)));
endmodule

// File: tb/tb_gpio_mux_bank.sv
// Self-checking bench: a vector table of register write/readback pairs,
// then directed tests for reset, pad routing, open-drain and sync delay.
module tb_gpio_mux_bank;
    import gpio_mux_pkg::*;

    localparam int NP = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [NP-1:0]     bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [NP-1:0]     bus_rdata;
    logic [NP-1:0]     pad_in = '0;
    logic [4*NP-1:0]   periph_dout = '0;
    logic [4*NP-1:0]   periph_oe = '0;
    logic [NP-1:0]     pad_out, pad_oe, pad_pullup, pad_pulldown;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    gpio_mux_bank #(.NPINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .periph_dout(periph_dout), .periph_oe(periph_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pad_pulldown(pad_pulldown)
    );

    typedef struct packed {
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  32'h0000_00FF, 5'd5,  32'h0000_00FF, 8'd1},  // R1 oe set
        '{5'd4,  32'h0000_000F, 5'd5,  32'h0000_00F0, 8'd1},  // R1 oe clear
        '{5'd6,  32'hA5A5_0000, 5'd8,  32'hA5A5_0000, 8'd1},  // R1 out set
        '{5'd7,  32'h8000_0000, 5'd8,  32'h25A5_0000, 8'd1},  // R1 out clear
        '{5'd1,  32'h0000_F000, 5'd2,  32'hFFFF_0FFF, 8'd2},  // R2 give to periph
        '{5'd0,  32'h0000_3000, 5'd2,  32'hFFFF_3FFF, 8'd2},  // R2 take back
        '{5'd12, 32'h0000_0011, 5'd11, 32'hFFFF_FFEE, 8'd6},  // R6 pd drops pu
        '{5'd31, 32'h0000_FFFF, 5'd14, 32'h0000_0011, 8'd10}, // R10 unused addr
        '{5'd9,  32'h0000_0001, 5'd11, 32'hFFFF_FFEF, 8'd6},  // R6 pu set
        '{5'd13, 32'h0000_0010, 5'd14, 32'h0000_0001, 8'd1},  // R1 pd clear
        '{5'd18, 32'h1234_5678, 5'd18, 32'h1234_5678, 8'd8},  // R8 low select
        '{5'd19, 32'hCAFE_0000, 5'd19, 32'hCAFE_0000, 8'd8},  // R8 high select
        '{5'd15, 32'h0000_0003, 5'd17, 32'h0000_0003, 8'd1},  // R1 od set
        '{5'd5,  32'hFFFF_FFFF, 5'd5,  32'h0000_00F0, 8'd10}  // R10 status write
    };

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [NP-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [NP-1:0] rd;
        do_reset();

        // R9 reset state
        bus_read(5'd2, rd);  check("R9 ownership", rd, '1);
        bus_read(5'd11, rd); check("R9 pull-up", rd, '1);
        bus_read(5'd5, rd);  check("R9 output enable", rd, '0);
        bus_read(5'd18, rd); check("R9 low select", rd, '0);
        check("R9 pad_oe", pad_oe, '0);
        check("R9 pad_pulldown", pad_pulldown, '0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            bus_read(VECS[i].raddr, rd);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
        end
        // R10 set address reads zero
        bus_read(5'd3, rd); check("R10 set address read", rd, '0);
        check("R6 pad_pullup", pad_pullup, 32'hFFFF_FFEF);

        // R4 GPIO-owned pin
        do_reset();
        bus_write(5'd3, 32'h1);
        bus_write(5'd6, 32'h1);
        check("R4 pad_oe", pad_oe, 32'h1);
        check("R4 pad_out", pad_out & 32'h3, 32'h1);

        // R3 peripheral routing on pins 7:4, codes 00,01,10,11
        periph_dout = {{NP{1'b0}}, {NP{1'b1}}, {NP{1'b0}}, {NP{1'b1}}};
        periph_oe   = {{NP{1'b0}}, {NP{1'b1}}, {NP{1'b1}}, {NP{1'b0}}};
        bus_write(5'd1, 32'h0000_00F0);
        bus_write(5'd18, 32'h0000_00A0);
        bus_write(5'd19, 32'h0000_00C0);
        #1;
        check("R3 pad_out pins 7:4", {28'd0, pad_out[7:4]}, 32'h5);
        check("R3 pad_oe pins 7:4", {28'd0, pad_oe[7:4]}, 32'h6);
        check("R3 gpio pin kept", {31'd0, pad_out[0]}, 32'h1);

        // R7 open-drain on pin 0
        bus_write(5'd15, 32'h1);
        check("R7 released for high", {30'd0, pad_oe[0], pad_out[0]}, 32'h0);
        bus_write(5'd7, 32'h1);
        check("R7 driven low", {30'd0, pad_oe[0], pad_out[0]}, 32'h2);

        // R5 two-edge level delay
        bus_addr = 5'd20;
        @(negedge clk);
        pad_in = 32'h1357_2468;
        @(negedge clk);
        check("R5 one edge still old", bus_rdata, 32'h0);
        @(negedge clk);
        check("R5 two edges new", bus_rdata, 32'h1357_2468);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule